// File: doc/BRIEF.md
# Banked Interrupt Latch and Mask Controller

This block collects the event lines of a multi-function peripheral and presents them to a host as interrupt registers. Events are grouped eight to a register. For each group there is a raw level view, a sticky pending latch and an enable mask. All of them sit in one interrupt bank. A host reaches them with a 16-bit address: the bank number is in the upper byte and the register offset is in the lower byte. A second, miscellaneous bank holds a read-only revision code.

The register space is sparse. Of groups 1 to 24, only groups 1–10 and 19–24 carry latches and masks. The raw level view exists only for groups 1–8 and 19–24. Event lines are numbered densely over the implemented groups. A latch captures each rising edge of its event line and holds it until the host reads that latch register, and the read also clears it. A single registered interrupt output is high while any latched event is also unmasked. The register port is a plain synchronous strobe interface with no back-pressure. A read strobe returns its data one clock later, and a write strobe takes effect at the clock edge where it is sampled.

Top module: `irqbank_top`

## Requirements
- R1: The address upper byte selects the bank. In the interrupt bank (0x0E), the level, latch and mask families start at offsets 0x00, 0x20 and 0x40, and group n sits at family base + n − 1. In the miscellaneous bank (0x10), offset 0x80 holds the revision code.
- R2: Latch and mask registers exist only for groups 1–10 and 19–24, and level registers only for groups 1–8 and 19–24. Any other offset, and any other bank, reads 0x00.
- R3: Event line e belongs to dense index e/8 at bit e%8. Dense indices 0–9 are groups 1–10 and dense indices 10–15 are groups 19–24.
- R4: After reset every mask reads 0xFF, every latch reads 0x00, the interrupt output is 0 and the read data is 0x00.
- R5: A latch bit sets on a rising edge of its event line whatever the mask holds, and it stays set until its latch register is read.
- R6: A read strobe puts the addressed register on the read data one cycle later and holds it there until the next read. Reading a latch register returns its pending bits and clears them.
- R7: A rising edge that arrives in the same cycle as a read of its latch register is not returned by that read, and it stays pending for the next read.
- R8: A mask bit of 1 blocks its event and a 0 enables it. A mask write takes effect at the sampling edge. The interrupt output is the registered OR of latch AND NOT mask over all groups, so it rises one cycle after the latch sets.
- R9: Writes to level, latch and revision registers, to absent groups, and to other banks change nothing.
- R10: The revision register returns the REVISION parameter, which is one of 0x00, 0x10 or 0x11.
- R11: A level register returns the current levels of its group's eight event lines, delayed by one register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 16 | Bank in [15:8], offset in [7:0] |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the cycle after reg_rd |
| event_in | input | 128 | Event lines, dense numbering |
| irq_out | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with its default geometry of ten low groups, six high groups starting at group 19, level registers on the first eight low groups, and revision 0x11. This configuration is small enough to sweep all 256 offsets of the interrupt bank and to raise each of the 128 event lines one at a time. Each event is checked against its level and latch registers and its dense-to-group mapping. The configuration also reaches the ragged edges of the map: group 9 and 10 latches that have no level register, and the 11–18 gap.

// File: rtl/irqbank_pkg.sv
package irqbank_pkg;
  localparam int unsigned EVT_PER_GRP = 8;
  localparam int unsigned DATA_W      = 8;
  localparam int unsigned ADDR_W      = 16;

  typedef enum logic [2:0] {
    FAM_NONE,
    FAM_SRC,
    FAM_LATCH,
    FAM_MASK,
    FAM_REV
  } fam_e;

  typedef struct packed {
    fam_e       fam;
    logic [7:0] idx;
  } dec_s;
endpackage

// File: rtl/irqbank_decode.sv
module irqbank_decode
  import irqbank_pkg::*;
#(
  parameter int unsigned LO_GROUPS     = 10,
  parameter int unsigned HI_FIRST      = 19,
  parameter int unsigned HI_GROUPS     = 6,
  parameter int unsigned SRC_LO_GROUPS = 8,
  parameter logic [7:0]  INT_BANK      = 8'h0E,
  parameter logic [7:0]  MISC_BANK     = 8'h10,
  parameter logic [7:0]  SRC_BASE      = 8'h00,
  parameter logic [7:0]  LATCH_BASE    = 8'h20,
  parameter logic [7:0]  MASK_BASE     = 8'h40,
  parameter logic [7:0]  REV_OFFSET    = 8'h80
) (
  input  logic [ADDR_W-1:0] addr_i,
  output dec_s              dec_o
);
  localparam logic [8:0] SPAN9   = 9'(HI_FIRST + HI_GROUPS - 1);
  localparam logic [8:0] LO9     = 9'(LO_GROUPS);
  localparam logic [8:0] HIF9    = 9'(HI_FIRST);
  localparam logic [8:0] HIL9    = 9'(HI_FIRST + HI_GROUPS - 1);
  localparam logic [8:0] SRCLO9  = 9'(SRC_LO_GROUPS);

  logic [7:0] bank, off;
  logic [8:0] rel_src, rel_lat, rel_msk, grp;
  logic       hit_src, hit_lat, hit_msk;
  logic       lo_hit, hi_hit, src_ok;
  logic [8:0] dense;

  assign bank    = addr_i[15:8];
  assign off     = addr_i[7:0];
  assign rel_src = {1'b0, off} - {1'b0, SRC_BASE};
  assign rel_lat = {1'b0, off} - {1'b0, LATCH_BASE};
  assign rel_msk = {1'b0, off} - {1'b0, MASK_BASE};
  assign hit_src = (off >= SRC_BASE)   && (rel_src < SPAN9);
  assign hit_lat = (off >= LATCH_BASE) && (rel_lat < SPAN9);
  assign hit_msk = (off >= MASK_BASE)  && (rel_msk < SPAN9);

  always_comb begin
    if (hit_src)      grp = rel_src + 9'd1;
    else if (hit_lat) grp = rel_lat + 9'd1;
    else              grp = rel_msk + 9'd1;
  end

  assign lo_hit = (grp >= 9'd1) && (grp <= LO9);
  assign hi_hit = (grp >= HIF9) && (grp <= HIL9);
  assign src_ok = ((grp >= 9'd1) && (grp <= SRCLO9)) || hi_hit;
  assign dense  = lo_hit ? (grp - 9'd1) : (grp - HIF9 + LO9);

  always_comb begin
    dec_o.fam = FAM_NONE;
    dec_o.idx = dense[7:0];
    if (bank == INT_BANK) begin
      if (hit_src && src_ok)                  dec_o.fam = FAM_SRC;
      else if (hit_lat && (lo_hit || hi_hit)) dec_o.fam = FAM_LATCH;
      else if (hit_msk && (lo_hit || hi_hit)) dec_o.fam = FAM_MASK;
    end else if (bank == MISC_BANK && off == REV_OFFSET) begin
      dec_o.fam = FAM_REV;
    end
    if (dec_o.fam == FAM_NONE || dec_o.fam == FAM_REV) dec_o.idx = 8'h00;
  end
endmodule

// File: rtl/irqbank_group.sv
module irqbank_group
  import irqbank_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [EVT_PER_GRP-1:0] ev_i,
  input  logic                   clr_i,
  input  logic                   we_i,
  input  logic [DATA_W-1:0]      wdata_i,
  output logic [EVT_PER_GRP-1:0] latch_o,
  output logic [EVT_PER_GRP-1:0] mask_o,
  output logic [EVT_PER_GRP-1:0] src_o
);
  logic [EVT_PER_GRP-1:0] ev_q, latch_q, mask_q, rise;

  assign rise = ev_i & ~ev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ev_q    <= '0;
      latch_q <= '0;
      mask_q  <= '1;
    end else begin
      ev_q    <= ev_i;
      latch_q <= (clr_i ? '0 : latch_q) | rise;
      if (we_i) mask_q <= wdata_i[EVT_PER_GRP-1:0];
    end
  end

  assign latch_o = latch_q;
  assign mask_o  = mask_q;
  assign src_o   = ev_q;

  assert_latch_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((latch_q & $past(latch_q)) == $past(latch_q)));

  assert_edge_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> ((latch_q & $past(ev_i & ~ev_q)) == $past(ev_i & ~ev_q)));

  assert_mask_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (mask_q == $past(wdata_i[EVT_PER_GRP-1:0])));
endmodule

// File: rtl/irqbank_top.sv
module irqbank_top
  import irqbank_pkg::*;
#(
  parameter int unsigned LO_GROUPS     = 10,
  parameter int unsigned HI_FIRST      = 19,
  parameter int unsigned HI_GROUPS     = 6,
  parameter int unsigned SRC_LO_GROUPS = 8,
  parameter logic [7:0]  INT_BANK      = 8'h0E,
  parameter logic [7:0]  MISC_BANK     = 8'h10,
  parameter logic [7:0]  REVISION      = 8'h11
) (
  input  logic                                       clk,
  input  logic                                       rst_n,
  input  logic [15:0]                                reg_addr,
  input  logic                                       reg_rd,
  input  logic                                       reg_wr,
  input  logic [7:0]                                 reg_wdata,
  output logic [7:0]                                 reg_rdata,
  input  logic [(LO_GROUPS+HI_GROUPS)*8-1:0]         event_in,
  output logic                                       irq_out
);
  localparam int unsigned NUM_IDX = LO_GROUPS + HI_GROUPS;
  localparam int unsigned IDX_W   = (NUM_IDX > 1) ? $clog2(NUM_IDX) : 1;

  dec_s dec;
  logic [IDX_W-1:0] sel;
  logic [EVT_PER_GRP-1:0] latch_a [NUM_IDX];
  logic [EVT_PER_GRP-1:0] mask_a  [NUM_IDX];
  logic [EVT_PER_GRP-1:0] src_a   [NUM_IDX];
  logic [NUM_IDX-1:0]     pend_vec;
  logic [NUM_IDX*EVT_PER_GRP-1:0] mask_flat;
  logic [DATA_W-1:0] rd_mux, rdata_q;
  logic              irq_q;

  irqbank_decode #(
    .LO_GROUPS(LO_GROUPS), .HI_FIRST(HI_FIRST), .HI_GROUPS(HI_GROUPS),
    .SRC_LO_GROUPS(SRC_LO_GROUPS), .INT_BANK(INT_BANK), .MISC_BANK(MISC_BANK)
  ) u_dec (
    .addr_i(reg_addr),
    .dec_o (dec)
  );

  assign sel = dec.idx[IDX_W-1:0];

  for (genvar i = 0; i < NUM_IDX; i++) begin : g_grp
    logic clr, we;
    assign clr = reg_rd && (dec.fam == FAM_LATCH) && (sel == IDX_W'(i));
    assign we  = reg_wr && (dec.fam == FAM_MASK)  && (sel == IDX_W'(i));

    irqbank_group u_grp (
      .clk    (clk),
      .rst_n  (rst_n),
      .ev_i   (event_in[i*EVT_PER_GRP +: EVT_PER_GRP]),
      .clr_i  (clr),
      .we_i   (we),
      .wdata_i(reg_wdata),
      .latch_o(latch_a[i]),
      .mask_o (mask_a[i]),
      .src_o  (src_a[i])
    );

    assign pend_vec[i] = |(latch_a[i] & ~mask_a[i]);
    assign mask_flat[i*EVT_PER_GRP +: EVT_PER_GRP] = mask_a[i];
  end

  always_comb begin
    unique case (dec.fam)
      FAM_SRC:   rd_mux = src_a[sel];
      FAM_LATCH: rd_mux = latch_a[sel];
      FAM_MASK:  rd_mux = mask_a[sel];
      FAM_REV:   rd_mux = REVISION;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= |pend_vec;
      if (reg_rd) rdata_q <= rd_mux;
    end
  end

  assign reg_rdata = rdata_q;
  assign irq_out   = irq_q;

  assert_mask_write_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && dec.fam != FAM_MASK) |=> $stable(mask_flat));

  assert_all_masked_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_flat) |=> !irq_out);

  assert_rev_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && dec.fam == FAM_REV) |=> (reg_rdata == REVISION));

  assert_unmapped_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && dec.fam == FAM_NONE) |=> (reg_rdata == 8'h00));
endmodule

// File: tb/tb_irqbank_top.sv
module tb_irqbank_top;
  localparam int CLK_PERIOD = 10;
  localparam int NEV = 128;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [15:0]  reg_addr = '0;
  logic         reg_rd = 1'b0;
  logic         reg_wr = 1'b0;
  logic [7:0]   reg_wdata = '0;
  logic [7:0]   reg_rdata;
  logic [NEV-1:0] event_in = '0;
  logic         irq_out;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  irqbank_top dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rd(reg_rd),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .event_in(event_in), .irq_out(irq_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_read(input logic [15:0] a, output logic [7:0] d);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic do_write(input logic [15:0] a, input logic [7:0] v);
    reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  function automatic int grp_of(input int idx);
    return (idx < 10) ? idx + 1 : idx - 10 + 19;
  endfunction

  function automatic bit grp_impl(input int g);
    return (g >= 1 && g <= 10) || (g >= 19 && g <= 24);
  endfunction

  function automatic bit src_impl(input int g);
    return (g >= 1 && g <= 8) || (g >= 19 && g <= 24);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R4: reset state at the ports
    check(irq_out == 1'b0, "R4 irq after reset", irq_out, 0);
    check(reg_rdata == 8'h00, "R4 rdata after reset", reg_rdata, 0);

    // R1 R2 R4: sweep of every interrupt-bank offset
    for (int off = 0; off < 256; off++) begin
      int exp;
      exp = 0;
      if (off >= 8'h40 && off < 8'h58 && grp_impl(off - 8'h40 + 1)) exp = 8'hFF;
      do_read(16'h0E00 | 16'(off), d);
      check(d == 8'(exp), "R1/R2/R4 offset sweep", d, exp);
    end
    // R10 R2: revision and other banks
    do_read(16'h1080, d); check(d == 8'h11, "R10 revision", d, 8'h11);
    do_read(16'h1081, d); check(d == 8'h00, "R2 misc other offset", d, 0);
    do_read(16'h0F40, d); check(d == 8'h00, "R2 other bank", d, 0);
    do_read(16'h0E80, d); check(d == 8'h00, "R2 rev offset in int bank", d, 0);

    // R3 R5 R6 R11 R8: walk every event line with all masks set
    for (int e = 0; e < NEV; e++) begin
      int idx, b, g, exps;
      idx = e / 8; b = e % 8; g = grp_of(idx);
      event_in[e] = 1'b1;
      @(negedge clk); @(negedge clk);
      check(irq_out == 1'b0, "R8 masked event keeps irq low", irq_out, 0);
      exps = src_impl(g) ? (1 << b) : 0;
      do_read(16'h0E00 + 16'(g - 1), d);
      check(d == 8'(exps), "R11/R2 level register", d, exps);
      do_read(16'h0E20 + 16'(g - 1), d);
      check(d == 8'(1 << b), "R3/R5 latch captures edge", d, 1 << b);
      do_read(16'h0E20 + 16'(g - 1), d);
      check(d == 8'h00, "R6 latch cleared by read", d, 0);
      event_in[e] = 1'b0;
      @(negedge clk);
    end

    // R8: unmask bit 0 of group 1, interrupt timing
    do_write(16'h0E40, 8'hFE);
    do_read(16'h0E40, d); check(d == 8'hFE, "R8 mask readback", d, 8'hFE);
    event_in[0] = 1'b1;
    @(negedge clk);
    check(irq_out == 1'b0, "R8 irq one cycle after latch", irq_out, 0);
    @(negedge clk);
    check(irq_out == 1'b1, "R8 irq asserted", irq_out, 1);
    do_read(16'h0E20, d); check(d == 8'h01, "R6 latch read", d, 1);
    check(irq_out == 1'b1, "R8 irq still registered", irq_out, 1);
    @(negedge clk);
    check(irq_out == 1'b0, "R8 irq drops after clear", irq_out, 0);
    event_in[0] = 1'b0;

    // R5: masked bit latches without irq
    event_in[1] = 1'b1;
    repeat (3) @(negedge clk);
    check(irq_out == 1'b0, "R5 masked bit no irq", irq_out, 0);
    do_read(16'h0E20, d); check(d == 8'h02, "R5 masked bit latched", d, 2);
    event_in[1] = 1'b0;

    // R7: edge coinciding with a latch read
    event_in[2] = 1'b1;
    @(negedge clk); @(negedge clk);
    event_in[3] = 1'b1;
    do_read(16'h0E20, d); check(d == 8'h04, "R7 read returns old bits", d, 4);
    do_read(16'h0E20, d); check(d == 8'h08, "R7 new edge kept", d, 8);
    event_in[3:2] = 2'b00;
    @(negedge clk);

    // R9: writes with no effect
    event_in[4] = 1'b1;
    @(negedge clk);
    do_write(16'h0E20, 8'h00);
    do_write(16'h0E00, 8'hFF);
    do_read(16'h0E20, d); check(d == 8'h10, "R9 latch write ignored", d, 8'h10);
    event_in[4] = 1'b0;
    do_write(16'h1080, 8'h00);
    do_read(16'h1080, d); check(d == 8'h11, "R9 revision write ignored", d, 8'h11);
    do_write(16'h0E4A, 8'h00);
    do_read(16'h0E4A, d); check(d == 8'h00, "R9 absent group mask", d, 0);
    do_write(16'h0F40, 8'h00);
    do_read(16'h0E40, d); check(d == 8'hFE, "R9 other bank write ignored", d, 8'hFE);
    repeat (2) @(negedge clk);
    check(irq_out == 1'b0, "R9 no irq from ignored writes", irq_out, 0);

    // R3 R8: high group 19 (dense index 10) enabled
    do_write(16'h0E52, 8'h00);
    event_in[10*8 + 5] = 1'b1;
    @(negedge clk); @(negedge clk);
    check(irq_out == 1'b1, "R3/R8 group 19 irq", irq_out, 1);
    do_read(16'h0E32, d); check(d == 8'h20, "R3 group 19 latch", d, 8'h20);
    event_in[10*8 + 5] = 1'b0;
    @(negedge clk);
    check(irq_out == 1'b0, "R8 group 19 irq cleared", irq_out, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule